// File: doc/BRIEF.md
# I2C Master Start/Stop Sequencer

This block is a single-byte I2C master engine driven by a host through plain register writes. A control register holds an enable bit, set-only request bits for start and stop conditions, two interrupt enables, a not-acknowledge status bit, a flush strobe and one stored option bit. A one-byte data register feeds an internal shift register. The engine drives the open-drain bus through two pull-low enables and reads the real SDA level back for the acknowledge bit.

The engine sends a byte MSB first, then releases SDA for a ninth clock and records a not-acknowledge if the line stays high. Start and stop requests are ordered against data availability and byte completion. A start waits for data, and a pending stop is sent before any pending start. As a result a stop followed by a new start, or a repeated start, leaves the bus in the right order. One reload value sets the length of every bus phase, and the same down-counter serves as a spare timer interrupt while the engine is disabled.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset the control readback is 0x00, the data register is empty (`tdre`=1), both bus enables are 0 and all interrupt outputs are 0.
- R2: Control bits 6 (start) and 5 (stop) are set by writing 1. Writing 0 to them while they are pending and the engine is enabled leaves them at 1.
- R3: Bit 7 is the enable. While it is 0 both bus enables are 0, start and stop read 0, and writing data or setting start produces no bus activity. Clearing it drops any pending start.
- R4: A pending start produces a start condition (SDA falling while SCL is high) only once the data register holds a byte. The start bit reads 0 once that condition has been generated.
- R5: Each byte goes out MSB first on eight SCL pulses. On the ninth pulse SDA is released. A high level sampled there sets the NAK status (readback bit 2), which clears at the next start condition or when 1 is written to bit 2.
- R6: A pending stop is generated after the byte in progress and its acknowledge phase complete, before any further byte. Stop means SDA rising while SCL is high. The stop bit reads 0 afterwards.
- R7: When stop and start are both pending at the end of a byte, the stop condition is sent first and then a start condition for the byte waiting in the data register.
- R8: `tdre` goes to 1 when a byte moves from the data register to the shift register, and to 0 on a data write (`reg_sel`=1). Writing 1 to control bit 1 (flush) sets it to 1. Bit 1 always reads 0.
- R9: `tx_irq` and `tx_dma_req` are 1 exactly when enable (bit 7), transmit-interrupt enable (bit 3) and `tdre` are all 1.
- R10: With the enable at 0 and bit 4 at 1, `brg_irq` pulses once every `brg_reload` clocks. While the enable is 1, or bit 4 is 0, it stays 0.
- R11: Every bus phase lasts `brg_reload` clocks, so each SCL high pulse of a data bit is `brg_reload` clocks wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects data register |
| reg_wdata | input | 8 | Write data |
| brg_reload | input | RELOAD_W | Phase length in clocks (reload of down-counter) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ctl_q | output | 8 | Control/status readback |
| tdre | output | 1 | Data register empty |
| tx_irq | output | 1 | Transmit-empty interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| brg_irq | output | 1 | Timer interrupt while disabled |

## Verification
The assertions assume that the host never writes the data register while `tdre` is 0 during a transfer, never clears the enable in the middle of a byte, and keeps `brg_reload` at 1 or more. The stimulus writes data only after polling `tdre` high and disables the engine only while the bus is idle. It picks reload values from 2 to 5. A bus-level slave model drives SDA in the acknowledge window from a seeded random plan. A decoder rebuilds start, stop, byte and acknowledge events from the line levels alone.

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic [7:0]          reg_wdata,
  input  logic [RELOAD_W-1:0] brg_reload,
  input  logic                sda_in,
  output logic                scl_oe,
  output logic                sda_oe,
  output logic [7:0]          ctl_q,
  output logic                tdre,
  output logic                tx_irq,
  output logic                tx_dma_req,
  output logic                brg_irq
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BLO, S_BHI, S_ALO, S_AHI, S_HOLD, S_PLO, S_PHI, S_RLO, S_RHI
  } state_t;

  state_t              st;
  logic                en, start_p, stop_p, birq_en, txi_en, nak, filt;
  logic [7:0]          dreg, sreg;
  logic [2:0]          bcnt;
  logic [RELOAD_W-1:0] cnt;
  logic                tick;

  assign tick = (cnt == RELOAD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt <= RELOAD_W'(1)) cnt <= brg_reload;
    else cnt <= cnt - RELOAD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {en, start_p, stop_p, birq_en, txi_en, nak, filt} <= '0;
      dreg <= '0;
      sreg <= '0;
      bcnt <= '0;
      tdre <= 1'b1;
    end else begin
      if (reg_wr && reg_sel) begin
        dreg <= reg_wdata;
        tdre <= 1'b0;
      end
      if (reg_wr && !reg_sel) begin
        en      <= reg_wdata[7];
        start_p <= reg_wdata[7] & (start_p | reg_wdata[6]);
        stop_p  <= reg_wdata[7] & (stop_p | reg_wdata[5]);
        birq_en <= reg_wdata[4];
        txi_en  <= reg_wdata[3];
        filt    <= reg_wdata[0];
        if (reg_wdata[2]) nak <= 1'b0;
        if (reg_wdata[1]) tdre <= 1'b1;
      end
      if (!en) st <= S_IDLE;
      else if (tick) begin
        case (st)
          S_IDLE: if (stop_p) stop_p <= 1'b0;
                  else if (start_p && !tdre) st <= S_START;
          S_START: begin
            start_p <= 1'b0;
            nak     <= 1'b0;
            sreg    <= dreg;
            tdre    <= 1'b1;
            bcnt    <= '0;
            st      <= S_BLO;
          end
          S_BLO: st <= S_BHI;
          S_BHI: if (bcnt == 3'd7) st <= S_ALO;
                 else begin
                   bcnt <= bcnt + 3'd1;
                   sreg <= {sreg[6:0], 1'b0};
                   st   <= S_BLO;
                 end
          S_ALO: st <= S_AHI;
          S_AHI: begin
            if (sda_in) nak <= 1'b1;
            st <= S_HOLD;
          end
          S_HOLD: if (stop_p) st <= S_PLO;
                  else if (start_p) begin
                    if (!tdre) st <= S_RLO;
                  end else if (!tdre) begin
                    sreg <= dreg;
                    tdre <= 1'b1;
                    bcnt <= '0;
                    st   <= S_BLO;
                  end
          S_PLO: st <= S_PHI;
          S_PHI: begin
            stop_p <= 1'b0;
            st     <= S_IDLE;
          end
          S_RLO: st <= S_RHI;
          S_RHI: st <= S_START;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign scl_oe = (st == S_BLO) || (st == S_ALO) || (st == S_HOLD) ||
                  (st == S_PLO) || (st == S_RLO);

  always_comb begin
    case (st)
      S_START, S_PLO, S_PHI: sda_oe = 1'b1;
      S_BLO, S_BHI:          sda_oe = ~sreg[7];
      default:               sda_oe = 1'b0;
    endcase
  end

  assign ctl_q      = {en, start_p, stop_p, birq_en, txi_en, nak, 1'b0, filt};
  assign tx_irq     = en & txi_en & tdre;
  assign tx_dma_req = en & txi_en & tdre;
  assign brg_irq    = ~en & birq_en & tick;
endmodule

// File: rtl/i2c_seq_master_chk.sv
module i2c_seq_master_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic start_p,
  input logic stop_p,
  input logic txi_en,
  input logic tdre,
  input logic tx_irq,
  input logic brg_irq,
  input logic scl_oe,
  input logic sda_oe
);
  assert_off_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!scl_oe && !sda_oe && !start_p && !stop_p));

  assert_start_after_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(start_p)) |-> ($past(sda_oe) && !$past(scl_oe)));

  assert_stop_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(stop_p)) |-> (!scl_oe && !sda_oe));

  assert_txirq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tdre && txi_en && en));

  assert_brg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !brg_irq);
endmodule

bind i2c_seq_master i2c_seq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_q[7]), .start_p(ctl_q[6]), .stop_p(ctl_q[5]),
  .txi_en(ctl_q[3]), .tdre(tdre), .tx_irq(tx_irq), .brg_irq(brg_irq),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_seq_master_tb.sv
`timescale 1ns/1ps
module i2c_seq_master_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, reg_wr, reg_sel;
  logic [7:0]  reg_wdata;
  logic [15:0] brg_reload;
  logic        sda_in, scl_oe, sda_oe, tdre, tx_irq, tx_dma_req, brg_irq;
  logic [7:0]  ctl_q;

  i2c_seq_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .brg_reload(brg_reload), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ctl_q(ctl_q), .tdre(tdre), .tx_irq(tx_irq), .tx_dma_req(tx_dma_req), .brg_irq(brg_irq)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam int EV_S = 1000, EV_P = 1001;
  int  ev[0:63];
  int  nev = 0, gbyte = 0, r = 0, hi = 0, lastw = 0;
  bit  win = 0, p_scl = 1, p_sda = 1;
  bit  [7:0] shb;
  bit  nak_plan[0:255];
  bit  [7:0] tx_b[0:3];

  wire scl_l = !scl_oe;
  wire sda_l = !(sda_oe | (win & !nak_plan[gbyte]));
  assign sda_in = sda_l;

  function automatic void log_ev(input int code);
    if (nev < 64) ev[nev] = code;
    nev++;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_l && p_sda && !sda_l) begin
        log_ev(EV_S); r = 0; win = 0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        log_ev(EV_P); r = 0; win = 0;
      end else begin
        if (!p_scl && scl_l) begin
          r++; hi = 1;
          if (r <= 8) shb = {shb[6:0], sda_l};
          if (r == 9) begin
            log_ev((sda_l ? 256 : 0) + int'(shb));
            check(lastw == int'(brg_reload), "R11 scl high width", lastw, int'(brg_reload));
          end
        end else if (p_scl && scl_l) hi++;
        if (p_scl && !scl_l) begin
          lastw = hi;
          if (r == 8) win = 1;
          else if (r == 9) begin win = 0; r = 0; gbyte++; end
        end
      end
      p_scl = scl_l;
      p_sda = sda_l;
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R6 actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_tdre();
    while (!tdre) @(negedge clk);
  endtask

  task automatic wait_stop_clear();
    do @(negedge clk); while (ctl_q[5]);
  endtask

  task automatic run_xfer(input int n, input int rl);
    int base, exp_nak, e;
    brg_reload = 16'(rl);
    repeat (3 * rl + 8) @(negedge clk);
    nev = 0; base = gbyte; exp_nak = 0;
    wr(1'b1, tx_b[0]);
    check(tdre == 1'b0, "R8 write clears empty", tdre, 0);
    wr(1'b0, 8'hC8);
    for (int i = 1; i < n; i++) begin
      wait_tdre();
      wr(1'b1, tx_b[i]);
    end
    wait_tdre();
    wr(1'b0, 8'hA8);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    check(nev == n + 2, "R6 event count", nev, n + 2);
    check(ev[0] == EV_S, "R4 start first", ev[0], EV_S);
    for (int i = 0; i < n; i++) begin
      e = (nak_plan[base + i] ? 256 : 0) + int'(tx_b[i]);
      check(ev[1 + i] == e, "R5 byte and ack", ev[1 + i], e);
      exp_nak |= int'(nak_plan[base + i]);
    end
    check(ev[n + 1] == EV_P, "R6 stop last", ev[n + 1], EV_P);
    check(int'(ctl_q[2]) == exp_nak, "R5 nak status", int'(ctl_q[2]), exp_nak);
  endtask

  int cnt;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) nak_plan[i] = ($urandom_range(0, 3) == 0);
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; brg_reload = 16'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    check(tdre == 1'b1, "R1 tdre", tdre, 1);
    check(!scl_oe && !sda_oe, "R1 bus released", {scl_oe, sda_oe}, 0);
    check(!tx_irq && !tx_dma_req && !brg_irq, "R1 irqs", {tx_irq, tx_dma_req, brg_irq}, 0);

    // R9 / R8
    wr(1'b0, 8'h08);
    check(tx_irq == 1'b0, "R9 irq needs enable", tx_irq, 0);
    wr(1'b0, 8'h88);
    check(tx_irq && tx_dma_req, "R9 irq and dma", {tx_irq, tx_dma_req}, 3);
    wr(1'b1, 8'h33);
    check(tdre == 1'b0, "R8 data write", tdre, 0);
    check(!tx_irq && !tx_dma_req, "R9 irq off when full", {tx_irq, tx_dma_req}, 0);
    wr(1'b0, 8'h8A);
    check(tdre == 1'b1, "R8 flush", tdre, 1);
    check(ctl_q[1] == 1'b0, "R8 flush reads 0", ctl_q[1], 0);
    check(tx_irq == 1'b1, "R9 irq after flush", tx_irq, 1);
    wr(1'b0, 8'h00);

    // R10
    brg_reload = 16'd3;
    wr(1'b0, 8'h10);
    repeat (10) @(negedge clk);
    cnt = 0;
    repeat (30) begin @(negedge clk); if (brg_irq) cnt++; end
    check(cnt == 10, "R10 timer pulses", cnt, 10);
    wr(1'b0, 8'h90);
    cnt = 0;
    repeat (30) begin @(negedge clk); if (brg_irq) cnt++; end
    check(cnt == 0, "R10 ignored when enabled", cnt, 0);
    wr(1'b0, 8'h00);
    cnt = 0;
    repeat (30) begin @(negedge clk); if (brg_irq) cnt++; end
    check(cnt == 0, "R10 disabled bit", cnt, 0);

    // R3
    nev = 0;
    wr(1'b1, 8'h77);
    wr(1'b0, 8'h40);
    repeat (30) @(negedge clk);
    check(ctl_q[6] == 1'b0, "R3 start blocked when off", ctl_q[6], 0);
    check(nev == 0, "R3 no bus activity", nev, 0);
    wr(1'b0, 8'h02);
    wr(1'b0, 8'hC0);
    check(ctl_q[6] == 1'b1, "R3 start pending", ctl_q[6], 1);
    wr(1'b0, 8'h00);
    check(ctl_q == 8'h00, "R3 disable clears start", ctl_q, 0);
    check(!scl_oe && !sda_oe, "R3 released", {scl_oe, sda_oe}, 0);

    // R4 / R2: start waits for data
    nev = 0;
    wr(1'b0, 8'hC0);
    repeat (40) @(negedge clk);
    check(nev == 0, "R4 no start without data", nev, 0);
    check(ctl_q[6] == 1'b1, "R4 start still pending", ctl_q[6], 1);
    wr(1'b0, 8'h80);
    check(ctl_q[6] == 1'b1, "R2 write 0 keeps start", ctl_q[6], 1);
    wr(1'b1, 8'h5A);
    while (ctl_q[6]) @(negedge clk);
    @(negedge clk);
    check(nev == 1 && ev[0] == EV_S, "R4 start after data", ev[0], EV_S);
    wait_tdre();
    wr(1'b0, 8'hA0);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    check(nev == 3 && ev[2] == EV_P, "R6 stop after byte", ev[2], EV_P);
    check((ev[1] & 255) == 8'h5A, "R5 byte value", ev[1] & 255, 8'h5A);
    wr(1'b0, 8'h84);
    check(ctl_q[2] == 1'b0, "R5 nak write-1 clear", ctl_q[2], 0);

    // R7 / R2: stop then repeated start
    brg_reload = 16'd3;
    repeat (12) @(negedge clk);
    nev = 0;
    wr(1'b1, 8'hA5);
    wr(1'b0, 8'hC8);
    wait_tdre();
    wr(1'b1, 8'h3C);
    wr(1'b0, 8'hE8);
    wr(1'b0, 8'h88);
    check(ctl_q[6] && ctl_q[5], "R2 write 0 keeps start and stop", {ctl_q[6], ctl_q[5]}, 3);
    while (ctl_q[6] || ctl_q[5]) @(negedge clk);
    wait_tdre();
    wr(1'b0, 8'hA8);
    wait_stop_clear();
    repeat (4) @(negedge clk);
    check(nev == 6, "R7 event count", nev, 6);
    check(ev[2] == EV_P, "R7 stop before restart", ev[2], EV_P);
    check(ev[3] == EV_S, "R7 start after stop", ev[3], EV_S);
    check((ev[1] & 255) == 8'hA5 && (ev[4] & 255) == 8'h3C, "R7 byte order", ev[4] & 255, 8'h3C);
    check(ev[5] == EV_P, "R6 final stop", ev[5], EV_P);

    // random transfers
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < 4; i++) tx_b[i] = 8'($urandom_range(0, 255));
      run_xfer($urandom_range(1, 3), $urandom_range(2, 5));
    end

    summary();
    $finish;
  end
endmodule